// File: doc/BRIEF.md
# Timer Event and Alarm Controller

This block gathers every timing event around a free-running 64-bit time counter into one latched event register and drives a single interrupt line from it. Two alarm comparators watch the current time and flag the cycle in which it equals a programmed 64-bit value. Two asynchronous trigger inputs are synchronized, edge-detected and used to capture the current time into per-trigger timestamp registers. Three periodic-pulse strobes from a pulse generator elsewhere land in the same register.

Software sees a small word-addressed register window. Event bits are cleared by writing ones. A mask register selects which latched events raise the interrupt. The time counter and the pulse generator sit outside this block. The register port is a plain control interface with no back-pressure: a write takes effect at the clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` combinationally.

Top module: `tmr_evt_ctrl`

## Requirements
- R1: After reset the control, event and mask registers, both alarm values, both captures and `irq` are all zero, both alarms are disarmed, and `alarm_out` is low.
- R2: Event bit positions: pulse strobes 0, 1 and 2 set bits 7, 6 and 5. Alarm 1 and alarm 2 set bits 16 and 17. Trigger 1 and trigger 2 captures set bits 24 and 25. A `pulse_in` bit that is high in a cycle sets its event bit at that clock edge.
- R3: Writing the event register (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R4: The mask register (address 2) uses the event bit positions. `irq` is high exactly when some event bit and its mask bit are both 1. A masked-off event still latches.
- R5: An alarm is loaded by writing its low word and then its high word. The high-word write arms it. While armed, the cycle in which `cur_time` equals the 64-bit value sets the alarm's event bit at that edge and disarms the alarm, so it fires only once.
- R6: Writing an alarm's low word disarms it. No match is reported until the high word is written again.
- R7: Each trigger input passes through two synchronizer flops before edge detection. Control bit 8 (trigger 1) and bit 9 (trigger 2) select the active edge: 0 selects rising and 1 selects falling. An edge on the opposite side has no effect. On an active edge the current time is stored in the trigger's capture register and its event bit is set, three clock edges after the input changes.
- R8: A capture that occurs while the previous capture's event bit is still set overwrites the stored timestamp.
- R9: Each `alarm_out` bit pulses for one cycle, in the cycle after its alarm matches. Control bit 31 (alarm 1) and bit 30 (alarm 2) invert it, so a set bit gives an idle-high, active-low output.
- R10: Register word addresses: 0 control (only bits 31, 30, 9 and 8 are stored), 1 event, 2 mask, 4/5 alarm 1 low/high, 6/7 alarm 2 low/high, 8/9 capture 1 low/high, 10/11 capture 2 low/high. The capture registers are read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 64 | Current time from the time counter |
| pulse_in | input | 3 | Periodic-pulse strobes, one cycle each |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt: OR of masked event bits |
| alarm_out | output | 2 | Alarm match pulses, polarity per control |

## Verification
A software clear of an event bit and a new hardware set of the same bit can land in one clock edge. The bench provokes this by driving a pulse strobe high during the same cycle as a write-one clear of that bit. It judges the result by reading the event register afterwards and expecting the bit still set. A clear on its own, with no strobe, is checked separately and must drop the bit.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVENT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 4'd2;
  localparam int                A_ALM_BASE = 4;
  localparam int                A_CAP_BASE = 8;

  localparam int B_PULSE0 = 7;
  localparam int B_ALM0   = 16;
  localparam int B_CAP0   = 24;

  localparam int B_POL0   = 31;
  localparam int B_EDGE0  = 8;

  localparam logic [31:0] CTRL_KEEP = 32'hC000_0300;
  localparam logic [31:0] EVT_VALID = 32'h0303_00E0;

  typedef struct packed {
    logic [1:0] pol;
    logic [1:0] fall;
  } ctrl_t;
endpackage

// File: rtl/tmr_alarm_cmp.sv
module tmr_alarm_cmp #(
  parameter int DW = 32,
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] val_o,
  output logic          hit_o
);
  localparam int HW = TW - DW;

  logic [DW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          armed_q;

  assign val_o = {hi_q, lo_q};
  assign hit_o = armed_q && (time_i == val_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata[HW-1:0];
      if (wr_hi)                armed_q <= 1'b1;
      else if (wr_lo || hit_o)  armed_q <= 1'b0;
    end
  end

  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !wr_hi) |=> !hit_o);

  assert_lo_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !hit_o);
endmodule

// File: rtl/tmr_trig_cap.sv
module tmr_trig_cap #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_async,
  input  logic          fall_sel,
  input  logic [TW-1:0] time_i,
  output logic          stb_o,
  output logic [TW-1:0] cap_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;
  assign stb_o = fall_sel ? fall : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_o <= '0;
    end else begin
      s1_q <= trig_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (stb_o) cap_o <= time_i;
    end
  end

  assert_capture_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> (cap_o == $past(time_i)));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);
endmodule

// File: rtl/tmr_evt_reg.sv
module tmr_evt_reg #(
  parameter int          DW    = 32,
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_data,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_o  <= '0;
      mask_o <= '0;
    end else begin
      evt_o <= ((evt_o & ~clr_i) | set_i) & VALID[DW-1:0];
      if (mask_wr) mask_o <= mask_data & VALID[DW-1:0];
    end
  end

  assign irq_o = |(evt_o & mask_o);

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((evt_o & $past(set_i)) == $past(set_i)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((evt_o & $past(clr_i & ~set_i)) == '0));

  assert_no_mask_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TW      = 64,
  parameter int N_ALM   = 2,
  parameter int N_TRIG  = 2,
  parameter int N_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cur_time,
  input  logic [N_PULSE-1:0] pulse_in,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq,
  output logic [N_ALM-1:0]  alarm_out
);
  localparam int HW = TW - DW;

  logic [DW-1:0]    ctrl_q;
  logic [N_ALM-1:0] alm_hit, alm_out_q, alm_pol;
  logic [N_TRIG-1:0] cap_stb, edge_fall;
  logic [TW-1:0]    alm_val [N_ALM];
  logic [TW-1:0]    cap_val [N_TRIG];
  logic [DW-1:0]    evt_set, evt_clr, evt_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      alm_out_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data & CTRL_KEEP[DW-1:0];
      alm_out_q <= alm_hit;
    end
  end

  for (genvar a = 0; a < N_ALM; a++) begin : g_alm
    logic lo_we, hi_we;
    assign lo_we = wr_en && (wr_addr == ADDR_W'(A_ALM_BASE + 2*a));
    assign hi_we = wr_en && (wr_addr == ADDR_W'(A_ALM_BASE + 2*a + 1));
    assign alm_pol[a] = ctrl_q[B_POL0 - a];

    tmr_alarm_cmp #(.DW(DW), .TW(TW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (lo_we),
      .wr_hi  (hi_we),
      .wdata  (wr_data),
      .time_i (cur_time),
      .val_o  (alm_val[a]),
      .hit_o  (alm_hit[a])
    );
  end

  assign alarm_out = alm_out_q ^ alm_pol;

  for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
    assign edge_fall[t] = ctrl_q[B_EDGE0 + t];

    tmr_trig_cap #(.TW(TW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (trig_in[t]),
      .fall_sel   (edge_fall[t]),
      .time_i     (cur_time),
      .stb_o      (cap_stb[t]),
      .cap_o      (cap_val[t])
    );
  end

  always_comb begin
    evt_set = '0;
    for (int p = 0; p < N_PULSE; p++) evt_set[B_PULSE0 - p] = pulse_in[p];
    for (int a = 0; a < N_ALM; a++)   evt_set[B_ALM0 + a]   = alm_hit[a];
    for (int t = 0; t < N_TRIG; t++)  evt_set[B_CAP0 + t]   = cap_stb[t];
  end

  assign evt_clr = (wr_en && wr_addr == A_EVENT) ? wr_data : '0;

  tmr_evt_reg #(.DW(DW), .VALID(EVT_VALID)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_set),
    .clr_i     (evt_clr),
    .mask_wr   (wr_en && wr_addr == A_MASK),
    .mask_data (wr_data),
    .evt_o     (evt_q),
    .mask_o    (mask_q),
    .irq_o     (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL)  rd_data = ctrl_q;
    if (rd_addr == A_EVENT) rd_data = evt_q;
    if (rd_addr == A_MASK)  rd_data = mask_q;
    for (int a = 0; a < N_ALM; a++) begin
      if (rd_addr == ADDR_W'(A_ALM_BASE + 2*a))     rd_data = alm_val[a][DW-1:0];
      if (rd_addr == ADDR_W'(A_ALM_BASE + 2*a + 1)) rd_data = DW'(alm_val[a][TW-1:DW]);
    end
    for (int t = 0; t < N_TRIG; t++) begin
      if (rd_addr == ADDR_W'(A_CAP_BASE + 2*t))     rd_data = cap_val[t][DW-1:0];
      if (rd_addr == ADDR_W'(A_CAP_BASE + 2*t + 1)) rd_data = DW'(cap_val[t][TW-1:DW]);
    end
  end

  assert_alarm_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_hit[0] && $stable(ctrl_q)) |=> (alarm_out[0] != alm_pol[0]));

  assert_alarm_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit[0] |=> evt_q[B_ALM0]);
endmodule

// File: tb/tmr_evt_ctrl_tb.sv
module tmr_evt_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cur_time = '0;
  logic [2:0]  pulse_in = '0;
  logic [1:0]  trig_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic [1:0]  alarm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .pulse_in(pulse_in),
    .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .alarm_out(alarm_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 12; a++) begin
      rd(a[3:0], v);
      check("R1 reg", {32'd0, v}, 64'd0);
    end
    check("R1 irq", {63'd0, irq}, 64'd0);
    check("R1 alarm_out", {62'd0, alarm_out}, 64'd0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R10 ctrl keep", {32'd0, v}, 64'hC000_0300);
    wr(4'd0, 32'h0);
    wr(4'd8, 32'h1234_5678);
    rd(4'd8, v); check("R10 cap read-only", {32'd0, v}, 64'd0);
  endtask

  task automatic t_pulses();
    logic [31:0] v;
    @(negedge clk); pulse_in = 3'b101;
    @(negedge clk); pulse_in = 3'b000;
    rd(4'd1, v); check("R2 pulse bits", {32'd0, v}, 64'h0000_00A0);
    check("R4 masked no irq", {63'd0, irq}, 64'd0);
    wr(4'd1, 32'h0000_0020);
    rd(4'd1, v); check("R3 w1c partial", {32'd0, v}, 64'h0000_0080);
    wr(4'd1, 32'h0000_0000);
    rd(4'd1, v); check("R3 write zero keeps", {32'd0, v}, 64'h0000_0080);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'd2, 32'h0000_0080);
    rd(4'd2, v); check("R4 mask read", {32'd0, v}, 64'h0000_0080);
    @(negedge clk); pulse_in = 3'b010;
    @(negedge clk); pulse_in = 3'b000;
    check("R4 other bit no irq", {63'd0, irq}, 64'd0);
    @(negedge clk); pulse_in = 3'b001;
    @(negedge clk); pulse_in = 3'b000;
    check("R4 enabled irq", {63'd0, irq}, 64'd1);
    wr(4'd1, 32'h0000_0080);
    check("R4 irq drops on clear", {63'd0, irq}, 64'd0);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk); pulse_in = 3'b001;
    @(negedge clk); pulse_in = 3'b000;
    @(negedge clk);
    pulse_in = 3'b001; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h0000_0080;
    @(negedge clk);
    pulse_in = 3'b000; wr_en = 1'b0;
    rd(4'd1, v); check("R3 set wins over clear", {32'd0, v}, 64'h0000_0080);
    wr(4'd1, 32'h0000_0080);
    rd(4'd1, v); check("R3 lone clear", {32'd0, v}, 64'd0);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    cur_time = 64'h0000_0001_0000_0100;
    wr(4'd4, 32'h0000_0200);
    wr(4'd5, 32'h0000_0001);
    rd(4'd5, v); check("R10 alarm hi read", {32'd0, v}, 64'd1);
    @(negedge clk); cur_time = 64'h0000_0001_0000_0200;
    @(negedge clk);
    rd(4'd1, v); check("R5 alarm1 event", {32'd0, v}, 64'h0001_0000);
    check("R9 alarm pulse high", {62'd0, alarm_out}, 64'd1);
    @(negedge clk);
    check("R9 alarm pulse one cycle", {62'd0, alarm_out}, 64'd0);
    wr(4'd1, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd(4'd1, v); check("R5 one shot", {32'd0, v}, 64'd0);
    cur_time = 64'h0;
  endtask

  task automatic t_half();
    logic [31:0] v;
    wr(4'd6, 32'h0000_0050);
    wr(4'd7, 32'h0000_0002);
    wr(4'd6, 32'h0000_0060);
    @(negedge clk); cur_time = 64'h0000_0002_0000_0060;
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R6 no match while half", {32'd0, v}, 64'd0);
    wr(4'd7, 32'h0000_0002);
    @(negedge clk);
    rd(4'd1, v); check("R5 alarm2 event", {32'd0, v}, 64'h0002_0000);
    wr(4'd1, 32'hFFFF_FFFF);
    cur_time = 64'h0;
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr(4'd0, 32'h8000_0000);
    check("R9 idle inverted", {62'd0, alarm_out}, 64'd1);
    wr(4'd4, 32'h0000_0777);
    wr(4'd5, 32'h0);
    @(negedge clk); cur_time = 64'h777;
    @(negedge clk);
    check("R9 active low pulse", {62'd0, alarm_out}, 64'd0);
    @(negedge clk);
    check("R9 back idle", {62'd0, alarm_out}, 64'd1);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0);
    rd(4'd1, v);
    cur_time = 64'h0;
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    cur_time = 64'hAAAA_0000_BBBB_0001;
    @(negedge clk); trig_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R7 not before three edges", {32'd0, v}, 64'd0);
    @(negedge clk);
    rd(4'd1, v); check("R7 trig1 event", {32'd0, v}, 64'h0100_0000);
    rd(4'd8, v); check("R7 cap1 lo", {32'd0, v}, 64'hBBBB_0001);
    rd(4'd9, v); check("R7 cap1 hi", {32'd0, v}, 64'hAAAA_0000);
    cur_time = 64'h0000_0005_0000_0009;
    @(negedge clk); trig_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk); trig_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd8, v); check("R8 overwrite lo", {32'd0, v}, 64'h0000_0009);
    rd(4'd9, v); check("R8 overwrite hi", {32'd0, v}, 64'h0000_0005);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0000_0200);
    cur_time = 64'h0000_0007_0000_0003;
    @(negedge clk); trig_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd1, v); check("R7 opposite edge ignored", {32'd0, v}, 64'd0);
    rd(4'd10, v); check("R7 cap2 untouched", {32'd0, v}, 64'd0);
    @(negedge clk); trig_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd1, v); check("R7 trig2 falling event", {32'd0, v}, 64'h0200_0000);
    rd(4'd10, v); check("R7 cap2 lo", {32'd0, v}, 64'h0000_0003);
    rd(4'd11, v); check("R7 cap2 hi", {32'd0, v}, 64'h0000_0007);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_map();
    t_pulses();
    t_mask();
    t_collide();
    t_alarm();
    t_half();
    t_polarity();
    t_trigger();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule